// File: doc/BRIEF.md
# Phase-Staggered Six-Channel PWM Dimmer

This block drives six LED channel gate signals from one shared dimming period and one 8-bit brightness value. A free-running period counter advances only on a tick enable and wraps every 256 ticks. Each channel is high for `duty` ticks of every period, counted from that channel's own start offset. Staggering the channel starts spreads the current steps of the LED strings across the period. This lowers ripple and load transients on the supply.

The block has three ways to place the channel starts. With no stagger, all channels switch together. With even spacing, the starts are spread uniformly over the period. With a programmable step, each channel starts a fixed 7-bit number of ticks after the previous channel, and the on-interval wraps across the period boundary. A separate pass-through mode bypasses the generator, and every enabled channel then copies an external PWM input. Brightness and placement settings are captured only when the period wraps, so a change in the middle of a period cannot shorten or split a pulse.

Top module: `phase_pwm_dimmer`

## Requirements
- R1: While `rst_n` is low, all six bits of `gate` are 0, and the captured brightness and placement settings are cleared.
- R2: The period counter advances by one only in cycles where `tick` is 1, and it wraps from 255 to 0. A period is therefore 256 ticks. Each registered `gate` value reflects the counter value of the previous cycle.
- R3: When `mode_sel` is not 2'b00, `even_sp` = 0 and `step` = 0, the offset of every channel is 0. Channel k (bit k of `gate`) is then high exactly while the counter is below the captured duty.
- R4: When `even_sp` = 1, channel k has offset floor(k*256/6), which gives 0, 42, 85, 128, 170 and 213 for k = 0 to 5.
- R5: When `even_sp` = 0, channel k has offset (k*step) mod 256. Channel k is high while ((count - offset) mod 256) < duty, so its on-interval wraps across the period boundary.
- R6: A captured duty of 0 holds every channel low. A captured duty of 255 holds every enabled channel high for the whole period.
- R7: A channel whose bit in `ch_en` is 0 drives a constant 0, in both the pass-through mode and the generator modes.
- R8: `duty`, `even_sp` and `step` are captured only in a cycle where `tick` = 1 and the counter is 255. Values applied in any other cycle have no effect until the next wrap.
- R9: When `mode_sel` = 2'b00, `gate` on the next cycle equals `ch_en` ANDed with `ext_pwm` replicated six times.
- R10: When `even_sp` = 1, the value of `step` has no effect on the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the period counter by one |
| duty | input | 8 | Brightness; the number of on-ticks per period |
| even_sp | input | 1 | 1 selects even spacing of the channel starts |
| step | input | 7 | Start delay between successive channels, in ticks |
| ch_en | input | 6 | Enable for each channel; bit k controls channel k |
| mode_sel | input | 2 | 2'b00 selects pass-through; any other value selects the generator |
| ext_pwm | input | 1 | External PWM input used in pass-through mode |
| gate | output | 6 | Channel gate outputs; bit k drives channel k |

## Verification
The hardest case to reach is a settings change that lands in the middle of a period. It must be held back until the wrap, even when the new placement moves on-intervals across the period boundary. The bench reaches this case by writing every new configuration at an arbitrary point in a period. A reference model captures the settings only at the wrap, and the bench compares `gate` against it on every cycle over more than two periods. The sweep covers all offset modes and the end duty values, and one run gates `tick` irregularly so that the counter pauses in the middle of pulses.

// File: rtl/phase_pwm_dimmer.sv
`timescale 1ns/1ps
module phase_pwm_dimmer #(
  parameter int NCH = 6,
  parameter int CW  = 8,
  parameter int SW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [CW-1:0]  duty,
  input  logic           even_sp,
  input  logic [SW-1:0]  step,
  input  logic [NCH-1:0] ch_en,
  input  logic [1:0]     mode_sel,
  input  logic           ext_pwm,
  output logic [NCH-1:0] gate
);
  localparam int PER = 1 << CW;
  localparam logic [CW-1:0] TOP = CW'(PER - 1);

  logic [CW-1:0]  cnt, duty_s;
  logic [SW-1:0]  step_s;
  logic           even_s;
  logic [NCH-1:0] on;
  logic           wrap;

  assign wrap = tick && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_s <= '0;
      step_s <= '0;
      even_s <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) begin
        duty_s <= duty;
        step_s <= step;
        even_s <= even_sp;
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [CW-1:0] EVEN_OFF = CW'((k * PER) / NCH);
    logic [CW-1:0] off, rel;
    assign off   = even_s ? EVEN_OFF : CW'(k * int'(step_s));
    assign rel   = cnt - off;
    assign on[k] = (duty_s == TOP) || (rel < duty_s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gate <= '0;
    else if (mode_sel == 2'b00) gate <= ch_en & {NCH{ext_pwm}};
    else                     gate <= ch_en & on;
  end
endmodule

module phase_pwm_dimmer_chk #(
  parameter int NCH = 6,
  parameter int CW  = 8,
  parameter int SW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [NCH-1:0] ch_en,
  input logic [1:0]     mode_sel,
  input logic           ext_pwm,
  input logic [NCH-1:0] gate,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  duty_s,
  input logic [SW-1:0]  step_s,
  input logic           even_s
);
  localparam logic [CW-1:0] TOP = CW'((1 << CW) - 1);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2
  AST_NO_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00 && !even_s && step_s == '0) |=>
    ((gate == '0) || (gate == $past(ch_en)))); // R3
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00 && duty_s == '0) |=> (gate == '0)); // R6
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00 && duty_s == TOP) |=> (gate == $past(ch_en))); // R6
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gate & ~$past(ch_en)) == '0)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == TOP) |=> ($stable(duty_s) && $stable(step_s) && $stable(even_s))); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (gate == ($past(ch_en) & {NCH{$past(ext_pwm)}}))); // R9
endmodule

bind phase_pwm_dimmer phase_pwm_dimmer_chk #(.NCH(NCH), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ch_en(ch_en), .mode_sel(mode_sel),
  .ext_pwm(ext_pwm), .gate(gate), .cnt(cnt), .duty_s(duty_s), .step_s(step_s),
  .even_s(even_s)
);

// File: tb/phase_pwm_dimmer_bench.sv
`timescale 1ns/1ps
module phase_pwm_dimmer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] duty = '0;
  logic       even_sp = 1'b0;
  logic [6:0] step = '0;
  logic [5:0] ch_en = 6'h3F;
  logic [1:0] mode_sel = 2'b01;
  logic       ext_pwm = 1'b0;
  logic [5:0] gate;

  int total = 0, bad = 0;
  string cur_req = "R1";
  int gap_mode = 0;

  always #10 clk = ~clk;

  phase_pwm_dimmer u_phase_pwm_dimmer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty(duty), .even_sp(even_sp),
    .step(step), .ch_en(ch_en), .mode_sel(mode_sel), .ext_pwm(ext_pwm), .gate(gate)
  );

  // reference model built from the requirements
  int m_cnt = 0, m_duty = 0, m_step = 0;
  bit m_even = 0;
  logic [5:0] exp_gate = '0;

  function automatic bit ch_on(int k, int c, int d, bit ev, int st);
    int off, rel;
    off = ev ? (k * 256) / 6 : (k * st) % 256;
    rel = (c - off + 256) % 256;
    return (d == 255) || (rel < d);
  endfunction

  always @(posedge clk) begin
    logic [5:0] nx;
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_step = 0; m_even = 0; exp_gate = '0;
    end else begin
      for (int k = 0; k < 6; k++)
        nx[k] = ch_en[k] && ((mode_sel == 2'b00) ? ext_pwm
                                                 : ch_on(k, m_cnt, m_duty, m_even, m_step));
      exp_gate = nx;
      if (tick) begin
        if (m_cnt == 255) begin
          m_duty = duty; m_step = step; m_even = even_sp;
        end
        m_cnt = (m_cnt + 1) % 256;
      end
    end
  end

  task automatic check_now();
    total++;
    if (gate !== exp_gate) begin
      bad++;
      $display("FAIL %s: gate=%b expected=%b at %0t", cur_req, gate, exp_gate, $time);
    end
  endtask

  int cyc = 0;
  int lfsr = 32'h1ACE;
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      #1;
      cyc++;
      tick = (gap_mode != 0) ? ((cyc % 3) != 0) : 1'b1;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      ext_pwm = lfsr[0];
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dl[7] = '{0, 1, 37, 128, 200, 254, 255};
    int sl[4] = '{0, 1, 45, 127};
    duty = 8'd200;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    total++;
    if (gate !== 6'h00) begin
      bad++;
      $display("FAIL R1: gate=%b expected=%b", gate, 6'h00);
    end
    #1 rst_n = 1'b1;
    run(300);  // duty captured only at first wrap: R8
    for (int di = 0; di < 7; di++) begin
      for (int si = 0; si < 5; si++) begin
        duty = 8'(dl[di]);
        even_sp = (si == 4);
        step = (si == 4) ? 7'd45 : 7'(sl[si]);
        if (dl[di] == 0 || dl[di] == 255) cur_req = "R6";
        else if (si == 4) cur_req = "R4/R10";
        else if (sl[si] == 0) cur_req = "R3";
        else cur_req = "R5";
        run(600);
      end
    end
    cur_req = "R7";
    ch_en = 6'h15; duty = 8'd90; even_sp = 1'b1;
    run(600);
    cur_req = "R2";
    gap_mode = 1; ch_en = 6'h3F; even_sp = 1'b0; step = 7'd77; duty = 8'd150;
    run(1600);
    gap_mode = 0; tick = 1'b1;
    cur_req = "R8";
    duty = 8'd10; step = 7'd0;
    run(600);
    run(130);
    duty = 8'd250; step = 7'd100;
    run(600);
    cur_req = "R9";
    mode_sel = 2'b00;
    for (int p = 0; p < 4; p++) begin
      ch_en = 6'(6'h3F >> p) ^ 6'(p * 9);
      run(150);
    end
    mode_sel = 2'b10; ch_en = 6'h3F; cur_req = "R9";
    run(300);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule